// File: doc/BRIEF.md
# MDIO Command-Word Master

This block is a management-bus master driven through one 32-bit command/status word. Software writes a word that holds the PHY address, the register address, the direction and (for writes) sixteen data bits, with both the go bit and the enable bit set. The engine then shifts a Clause 22 management frame out on MDC/MDIO, drops the go/busy bit when the frame has ended, and for reads leaves the received sixteen bits in the low half of the same word.

MDC comes from the system clock through a parameterised half-period divider and rests low between frames. MDIO changes only when MDC falls, and read data is taken when MDC rises. During a read the master releases MDIO from the first turnaround bit to the end of the frame. A frame lasts 128*HALF_DIV system clocks. With the default divider at 100 MHz this is 2.56 us, well inside a 20 us budget.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads 0, MDC is low, MDIO output is 1 and the output enable is 0.
- R2: A write with bit 31 (go/busy) and bit 30 (enable) both set, while idle, starts a frame, and bit 31 reads 1 from the next clock.
- R3: Bit 31 stays 1 for exactly 128*HALF_DIV clocks after the start write and then clears on its own.
- R4: MDC is low whenever no frame runs and gives exactly 64 rising edges per frame, each high phase lasting HALF_DIV clocks.
- R5: The frame is 32 ones, then 01, then the opcode (01 write, 10 read; bit 27 set selects read), PHY address from bits 25:21, register address from bits 20:16, turnaround 10 on writes, then data bits 15:0 MSB first. Every bit is sampled at MDC rising edges.
- R6: On a write the output enable is 1 for all 64 bits. On a read it is 1 for the first 46 bits and 0 for the turnaround and the data bits.
- R7: After a read ends, bits 15:0 hold the 16 MDIO values sampled at the last 16 MDC rising edges, MSB first, and bits 27 and 25:16 keep their written values.
- R8: A write to the word while bit 31 is 1 is ignored: the frame on the wire and the word's fields do not change.
- R9: A write with bit 30 clear, or with bit 31 clear, starts no frame: bit 31 reads 0 and MDC stays low.
- R10: While a frame runs, MDIO output changes only in the clock in which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the command word |
| wdata_i | input | 32 | Command word write data |
| rdata_o | output | 32 | Command/status word read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A bit counter or shift register that gets out of step shows up as a misplaced field or a wrong opcode in the 64 bits the bench captures at MDC rising edges, and the wrong busy length appears the moment bit 31 drops. A wrong release point for the output enable, or a wrong sample edge for read data, shows up in the same frame as enable bits or returned data that do not match. A start guard that misses its case shows up within a few clocks, either as MDC toggling when it should rest or as busy rising when it should not.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int BUSY_BIT = 31;
  localparam int EN_BIT   = 30;
  localparam int RD_BIT   = 27;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int PHY_LSB  = 21;
  localparam int REG_LSB  = 16;
  localparam int PRE_W    = 32;
  localparam int FRAME_W  = PRE_W + 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int TA_POS   = PRE_W + 4 + 2*ADDR_W;
  localparam int DATA_POS = TA_POS + 2;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic rd, input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg, input logic [DATA_W-1:0] dat);
    logic [1:0] op;
    op = rd ? 2'b10 : 2'b01;
    return {{PRE_W{1'b1}}, 2'b01, op, phy, rg, 2'b10, dat};
  endfunction
endpackage

// File: rtl/mdc_div.sv
module mdc_div #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign rise_o = run_i && wrap && !mdc_q;
  assign fall_o = run_i && wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_tick_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  p_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift #(
  parameter int FRAME_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               bit_o,
  output logic [$clog2(FRAME_W)-1:0] idx_o,
  output logic               last_o
);
  localparam int IW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [IW-1:0]      idx_q;

  assign bit_o  = sr_q[FRAME_W-1];
  assign idx_o  = idx_q;
  assign last_o = (idx_q == IW'(FRAME_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '1;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= frame_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[FRAME_W-2:0], 1'b1};
      idx_q <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  p_no_load_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int IW = $clog2(FRAME_W);

  logic              busy_q, en_q, rd_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] data_q, rd_sh_q;
  logic              rise, fall, last, sr_bit, accept, done, idle_wr;
  logic [IW-1:0]     idx;
  logic [FRAME_W-1:0] frame;

  assign idle_wr = we_i && !busy_q;
  assign accept  = idle_wr && wdata_i[BUSY_BIT] && wdata_i[EN_BIT];
  assign done    = fall && last;
  assign frame   = build_frame(wdata_i[RD_BIT],
                               wdata_i[PHY_LSB +: ADDR_W],
                               wdata_i[REG_LSB +: ADDR_W],
                               wdata_i[DATA_W-1:0]);

  mdc_div #(.HALF(HALF_DIV)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_shift #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .frame_i(frame),
    .shift_i(fall),
    .bit_o  (sr_bit),
    .idx_o  (idx),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      en_q    <= 1'b0;
      rd_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      rd_sh_q <= '0;
    end else begin
      if (idle_wr) begin
        busy_q <= accept;
        en_q   <= wdata_i[EN_BIT];
        rd_q   <= wdata_i[RD_BIT];
        phy_q  <= wdata_i[PHY_LSB +: ADDR_W];
        reg_q  <= wdata_i[REG_LSB +: ADDR_W];
        data_q <= wdata_i[DATA_W-1:0];
      end else if (done) begin
        busy_q <= 1'b0;
        if (rd_q) data_q <= rd_sh_q;
      end
      // read bits land on MDC rising edges of the data phase
      if (busy_q && rd_q && rise && idx >= IW'(DATA_POS))
        rd_sh_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
    end
  end

  assign mdio_o    = busy_q ? sr_bit : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && idx >= IW'(TA_POS));
  assign rdata_o   = {busy_q, en_q, 2'b00, rd_q, 1'b0, phy_q, reg_q, data_q};

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !busy_q && wdata_i[BUSY_BIT] && wdata_i[EN_BIT] |=> busy_q);
  p_no_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !busy_q && !(wdata_i[BUSY_BIT] && wdata_i[EN_BIT]) |=> !busy_q && !mdc_o);
  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && we_i |=> $stable(phy_q) && $stable(reg_q) && $stable(rd_q));
  p_mdio_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !fall |=> $stable(mdio_o));
  p_write_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !rd_q |-> mdio_oe_o);
  p_idle_mdc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdc_o);
endmodule

// File: tb/test_mdio_cmd_engine.sv
module test_mdio_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int errs = 0, checks = 0, finished = 0;
  int ph_idx = 100;
  int nrise = 0;
  int viol = 0;
  logic [15:0] ph_resp = '0;
  logic [63:0] cap = '0, capoe = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_cmd_engine #(.HALF_DIV(HALF)) i_mdio_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model: drives response bits after MDC falls, pull-up otherwise
  assign mdio_in = (ph_idx >= 48 && ph_idx <= 63) ? ph_resp[63 - ph_idx] : 1'b1;
  always @(negedge mdc) ph_idx = ph_idx + 1;
  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_out};
    capoe = {capoe[62:0], mdio_oe};
    nrise = nrise + 1;
  end

  logic prev_mdio = 1'b1, prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (rst_n && rdata[31] && mdio_out !== prev_mdio && !(prev_mdc && !mdc))
      viol = viol + 1;
    prev_mdio = mdio_out;
    prev_mdc  = mdc;
  end

  task automatic chk(input logic ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = 32'hFFFF_FFFF;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  task automatic txn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] d, input logic [15:0] resp, input logic intrude);
    int cyc;
    int hi;
    logic [63:0] ef, mask;
    ph_resp = resp; ph_idx = 0; nrise = 0; hi = 0;
    @(negedge clk);
    we = 1'b1;
    wdata = {1'b1, 1'b1, 2'b00, rd, 1'b0, phy, rg, d};
    @(negedge clk);
    we = 1'b0;
    chk(rdata[31] === 1'b1, "R2 busy after start", {63'd0, rdata[31]}, 64'd1);
    cyc = 1;
    while (1) begin
      @(negedge clk);
      we = 1'b0;
      if (!rdata[31]) break;
      if (mdc) hi++;
      cyc++;
      if (intrude && cyc == 40) begin
        we = 1'b1;
        wdata = {2'b11, 2'b00, ~rd, 1'b0, ~phy, ~rg, ~d};
      end
      if (cyc > 5000) break;
    end
    chk(cyc == 128*HALF, "R3 busy length", 64'(cyc), 64'(128*HALF));
    chk(nrise == 64 && hi == 64*HALF, "R4 mdc edges/high time",
        {32'(nrise), 32'(hi)}, {32'd64, 32'(64*HALF)});
    ef = exp_frame(rd, phy, rg, d);
    mask = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    chk((cap & mask) === (ef & mask), rd ? "R6 read frame header" : "R5 write frame",
        cap & mask, ef & mask);
    chk(capoe === mask, "R6 output enable", capoe, mask);
    if (rd)
      chk(rdata[15:0] === resp && rdata[27] && rdata[25:21] === phy && rdata[20:16] === rg,
          "R7 read data and fields", 64'(rdata), 64'({1'b1, 1'b0, phy, rg, resp}));
    else
      chk(rdata[15:0] === d && !rdata[27] && rdata[25:21] === phy && rdata[20:16] === rg,
          intrude ? "R8 fields after ignored write" : "R5 fields kept",
          64'(rdata), 64'({1'b0, 1'b0, phy, rg, d}));
  endtask

  task automatic no_start(input logic [31:0] w);
    nrise = 0;
    @(negedge clk);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
    repeat (20) @(negedge clk);
    chk(rdata[31] === 1'b0 && nrise == 0 && mdc === 1'b0, "R9 no frame",
        {rdata[31], 31'(nrise), 32'(mdc)}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(rdata === 32'd0 && mdc === 1'b0 && mdio_out === 1'b1 && mdio_oe === 1'b0,
        "R1 reset state", {rdata, 28'd0, mdc, mdio_out, mdio_oe, 1'b0}, 64'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdata === 32'd0 && mdc === 1'b0, "R1 after release", 64'(rdata), 64'd0);
    // directed corners
    txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1'b0);
    txn(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0);
    txn(1'b1, 5'h15, 5'h0A, 16'h0000, 16'h8001, 1'b0);
    txn(1'b1, 5'h00, 5'h1F, 16'h0000, 16'h0000, 1'b0);
    txn(1'b0, 5'h05, 5'h12, 16'hA5C3, 16'h0000, 1'b1);
    no_start(32'hB000_1234 & ~32'h4000_0000);
    no_start(32'h4000_1234);
    // random
    for (int i = 0; i < 12; i++) begin
      logic [31:0] r;
      r = $urandom();
      txn(r[0], 5'($urandom()), 5'($urandom()), 16'($urandom()), 16'($urandom()), 1'b0);
    end
    chk(viol == 0, "R10 mdio only on mdc fall", 64'(viol), 64'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule